// File: doc/BRIEF.md
# GPIO Port with Atomic Set/Reset

This block is a 16-pin general-purpose I/O port with a 32-bit register bus. Software picks each pin's direction through a 2-bit mode field and a drive-strength setting through a 2-bit speed field. It writes output levels through an output data register and reads pin levels through an input data register. Each input pin passes through a two-flop synchronizer before it reaches that register.

A write-only set/reset register removes the need for read-modify-write on the output data. One bus write carries per-pin set bits in its low half and per-pin clear bits in its high half. Every marked pin changes on the same clock edge. Pins with no marked bit keep their level. Two software contexts can therefore drive different pins of the same port without a lock and without losing each other's updates.

A bus access is one cycle with `bus_en` high. `bus_we` selects a write or a read. Read data is registered: it appears on `bus_rdata` after the next clock edge and stays there until the next read.

Top module: `gpio_port_atomic`

## Requirements
- R1: While `rst_n` is low, every register clears to 0, `pin_out` and `pin_oe` are 0, and `bus_rdata` is 0. After reset, every register reads as 0.
- R2: The mode register is at offset 0x00, is 32 bits wide and reads back in full. The speed register is at offset 0x08 and is also 32 bits wide. The output data register is at offset 0x14. It keeps write bits 15:0, and its bits 31:16 read as 0.
- R3: The mode field of pin i sits at bits 2i+1:2i of the mode register. `pin_oe[i]` is 1 exactly when that field is 01. The codes 00, 10 and 11 keep `pin_oe[i]` at 0.
- R4: `pin_out[i]` equals bit i of the output data register. It takes a new written value on the clock edge that accepts the write.
- R5: The set/reset register is at offset 0x18. On the edge that accepts a write, a 1 in write bit i (0 to 15) drives output bit i to 1. A 1 in write bit 16+i drives output bit i to 0. Several pins may change in that one write.
- R6: In a set/reset write, any pin whose set bit and clear bit are both 0 keeps its output value.
- R7: If a set/reset write has both the set bit and the clear bit of a pin at 1, the pin goes to 1.
- R8: Reading the set/reset register returns 0.
- R9: The input data register is at offset 0x10. Its bits 15:0 hold the pin levels after a two-flop synchronizer, and bits 31:16 read as 0. A read issued in the same cycle as a pin change, or one cycle after it, returns the previous level. A read issued two or more cycles after the change returns the new level.
- R10: Writes to offset 0x10 or to any address other than 0x00, 0x08, 0x14 and 0x18 leave every register and output unchanged. Reads from unmapped addresses return 0.
- R11: The data for a read appears on `bus_rdata` after the clock edge that accepts the read. It holds through idle cycles and writes until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output level per pin |
| pin_oe | output | 16 | Output enable per pin |

## Verification
The assertions assume three things about the inputs:
- `bus_en` and `bus_we` stay low while reset is asserted.
- The bus signals are steady around each rising clock edge.
- `pin_in` changes only away from the clock edge. The synchronizer check compares its second stage with the pin value from two edges earlier.

The stimulus meets these assumptions as follows:
- All inputs are driven on the falling edge.
- The bus is held idle during reset.
- Pins change only at falling edges.

Random traffic mixes writes to every mapped register, writes to the input register and to unmapped offsets, set/reset words that have overlapping set and clear bits, and reads from any address. Directed sequences pin down the reset state, the synchronizer latency and the set-priority case.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SPEED = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_IN    = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_OUT   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SETCL = 8'h18;

    typedef enum logic [1:0] {
        PMODE_IN   = 2'b00,
        PMODE_OUT  = 2'b01,
        PMODE_ALT  = 2'b10,
        PMODE_ANLG = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;

    // cycles since reset, saturating; gates the latency check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd3)
            age_q <= age_q + 2'd1;
    end

    // R9: synchronized value lags the pin by two edges
    assert_sync_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (stab_q == $past(async_in, 2)));
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int unsigned NPINS = 16,
    parameter int unsigned DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    output logic [2*NPINS-1:0] mode_q,
    output logic [2*NPINS-1:0] speed_q,
    output logic [NPINS-1:0]  out_q
);
    localparam int unsigned HALF = DW / 2;
    localparam int unsigned MW   = 2 * NPINS;

    logic [NPINS-1:0] set_bits;
    logic [NPINS-1:0] clr_bits;
    logic             setcl_wr;
    logic             any_wr;

    assign set_bits = wdata[NPINS-1:0];
    assign clr_bits = wdata[HALF +: NPINS];
    assign setcl_wr = wr_en && (waddr == OFF_SETCL);
    assign any_wr   = wr_en && ((waddr == OFF_MODE) || (waddr == OFF_SPEED) ||
                                (waddr == OFF_OUT)  || (waddr == OFF_SETCL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            speed_q <= '0;
            out_q   <= '0;
        end else if (wr_en) begin
            unique case (waddr)
                OFF_MODE:  mode_q  <= wdata[MW-1:0];
                OFF_SPEED: speed_q <= wdata[MW-1:0];
                OFF_OUT:   out_q   <= wdata[NPINS-1:0];
                // clear first, then set: set wins on overlap
                OFF_SETCL: out_q   <= (out_q & ~clr_bits) | set_bits;
                default:   ;
            endcase
        end
    end

    // R5 / R7: every set bit lands as 1, even when its clear bit is also high
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        setcl_wr |=> ((out_q & $past(set_bits)) == $past(set_bits)));

    // R5: clear-only bits land as 0
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        setcl_wr |=> ((out_q & $past(clr_bits & ~set_bits)) == '0));

    // R6: unmarked pins keep their level
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        setcl_wr |=> (((out_q ^ $past(out_q)) & ~$past(set_bits | clr_bits)) == '0));

    // R10: without a write to a writable offset no register moves
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($stable(mode_q) && $stable(speed_q) && $stable(out_q)));
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux
    import gpx_pkg::*;
#(
    parameter int unsigned NPINS = 16,
    parameter int unsigned DW    = 32
) (
    input  logic [ADDR_W-1:0]  raddr,
    input  logic [2*NPINS-1:0] mode_q,
    input  logic [2*NPINS-1:0] speed_q,
    input  logic [NPINS-1:0]   out_q,
    input  logic [NPINS-1:0]   in_sync,
    output logic [DW-1:0]      rd_word
);
    localparam int unsigned MW = 2 * NPINS;

    always_comb begin
        rd_word = '0;
        unique case (raddr)
            OFF_MODE:  rd_word[MW-1:0]    = mode_q;
            OFF_SPEED: rd_word[MW-1:0]    = speed_q;
            OFF_IN:    rd_word[NPINS-1:0] = in_sync;
            OFF_OUT:   rd_word[NPINS-1:0] = out_q;
            default:   rd_word = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_atomic.sv
module gpio_port_atomic
    import gpx_pkg::*;
#(
    parameter int unsigned NPINS = 16,
    parameter int unsigned DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    localparam int unsigned MW = 2 * NPINS;

    logic [MW-1:0]    mode_q;
    logic [MW-1:0]    speed_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] in_sync;
    logic [DW-1:0]    rd_word;
    logic [DW-1:0]    rdata_q;
    logic             rd_stb;
    logic             wr_stb;

    assign rd_stb = bus_en && !bus_we;
    assign wr_stb = bus_en && bus_we;

    gpx_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    gpx_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb),
        .waddr   (bus_addr),
        .wdata   (bus_wdata),
        .mode_q  (mode_q),
        .speed_q (speed_q),
        .out_q   (out_q)
    );

    gpx_rdmux #(.NPINS(NPINS), .DW(DW)) u_rdmux (
        .raddr   (bus_addr),
        .mode_q  (mode_q),
        .speed_q (speed_q),
        .out_q   (out_q),
        .in_sync (in_sync),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_stb)
            rdata_q <= rd_word;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = out_q;

    for (genvar p = 0; p < NPINS; p++) begin : g_oe
        assign pin_oe[p] = (mode_q[2*p +: 2] == PMODE_OUT);
    end

    // R8: the set/reset offset never returns data
    assert_setcl_reads0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && (bus_addr == OFF_SETCL)) |-> (bus_rdata == '0));

    // R9: upper half of the input register is zero
    assert_in_upper0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && (bus_addr == OFF_IN)) |-> (bus_rdata[DW-1:NPINS] == '0));

    // R11: read data holds while no read is accepted
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_port_atomic_tb.sv
module gpio_port_atomic_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_mode = '0;
    logic [31:0] m_speed = '0;
    logic [15:0] m_out = '0;

    always #5 clk = ~clk;

    gpio_port_atomic u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    function automatic logic [15:0] f_oe(input logic [31:0] mode);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = (mode[2*i +: 2] == 2'b01);
        return r;
    endfunction

    function automatic logic [15:0] f_setcl(input logic [15:0] cur, input logic [31:0] w);
        return (cur & ~w[31:16]) | w[15:0];
    endfunction

    function automatic logic [31:0] f_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_mode;
            8'h08:   return m_speed;
            8'h10:   return {16'h0, pin_in};
            8'h14:   return {16'h0, m_out};
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit f_mapped(input logic [7:0] a);
        return (a == 8'h00) || (a == 8'h08) || (a == 8'h14) || (a == 8'h18);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        case (a)
            8'h00: m_mode = d;
            8'h08: m_speed = d;
            8'h14: m_out = d[15:0];
            8'h18: m_out = f_setcl(m_out, d);
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_pins(input string req);
        chk({req, " pin_out"}, {16'h0, pin_out}, {16'h0, m_out});
        chk({req, " pin_oe"}, {16'h0, pin_oe}, {16'h0, f_oe(m_mode)});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [15:0] prev;
        void'($urandom(32'h1234_5A5A));
        pin_in = 16'hA5C3;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1 rst pin_out", {16'h0, pin_out}, 32'h0);
        chk("R1 rst pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 rst rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every register reads 0 after reset (input reg reflects pins)
        bus_read(8'h00, rd); chk("R1 mode", rd, 32'h0);
        bus_read(8'h08, rd); chk("R1 speed", rd, 32'h0);
        bus_read(8'h14, rd); chk("R1 out", rd, 32'h0);
        bus_read(8'h18, rd); chk("R1/R8 setcl", rd, 32'h0);

        // R2: readback of full-width registers
        bus_write(8'h00, 32'hDEAD_BEEF); bus_read(8'h00, rd); chk("R2 mode", rd, 32'hDEAD_BEEF);
        bus_write(8'h08, 32'hFFFF_FFFF); bus_read(8'h08, rd); chk("R2 speed", rd, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_1234); bus_read(8'h14, rd); chk("R2 out upper0", rd, 32'h0000_1234);
        chk_pins("R4");

        // R3: each mode code on pin 0..3 : 00,01,10,11
        bus_write(8'h00, 32'h0000_00E4);
        chk("R3 codes", {16'h0, pin_oe}, 32'h0000_0002);
        bus_write(8'h00, 32'h5555_5555);
        chk("R3 all out", {16'h0, pin_oe}, 32'h0000_FFFF);

        // R5 multi-pin set and clear in one write
        bus_write(8'h14, 32'h0000_00F0);
        bus_write(8'h18, 32'h00F0_0F00);
        chk("R5 multi", {16'h0, pin_out}, 32'h0000_0F00);
        // R6: zero word keeps everything
        bus_write(8'h18, 32'h0);
        chk("R6 zero word", {16'h0, pin_out}, 32'h0000_0F00);
        // R7: both set and clear on bits 0 and 8
        bus_write(8'h18, 32'h0101_0101);
        chk("R7 set wins", {16'h0, pin_out}, 32'h0000_0F01);
        bus_read(8'h18, rd); chk("R8 setcl read", rd, 32'h0);

        // R10: writes to input reg and unmapped offsets
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h19, 32'hFFFF_0000);
        chk_pins("R10");
        bus_read(8'h14, rd); chk("R10 out kept", rd, {16'h0, m_out});
        bus_read(8'h00, rd); chk("R10 mode kept", rd, m_mode);
        bus_read(8'h0C, rd); chk("R10 unmapped read", rd, 32'h0);

        // R11: rdata holds across idle and writes
        bus_read(8'h00, rd);
        repeat (3) @(negedge clk);
        bus_write(8'h14, 32'h0000_0000);
        chk("R11 hold", bus_rdata, m_mode);

        // R9: synchronizer latency
        prev = pin_in;
        @(negedge clk);
        pin_in = ~prev;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h10;
        @(negedge clk);
        chk("R9 same cycle", bus_rdata, {16'h0, prev});
        @(negedge clk);
        chk("R9 one cycle", bus_rdata, {16'h0, prev});
        @(negedge clk);
        bus_en = 1'b0;
        chk("R9 two cycles", bus_rdata, {16'h0, ~prev});

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [31:0] d;
            logic [7:0] a;
            op = $urandom % 8;
            d = $urandom;
            case (op)
                0: begin bus_write(8'h00, d); chk_pins("R3"); end
                1: begin bus_write(8'h08, d); chk_pins("R2"); end
                2: begin bus_write(8'h14, d); chk_pins("R4"); end
                3, 4: begin
                    if (op == 4) d[31:16] = d[31:16] | d[15:0];
                    bus_write(8'h18, d); chk_pins("R5/R6/R7");
                end
                5: begin
                    a = 8'($urandom);
                    if (f_mapped(a)) a = 8'h10;
                    bus_write(a, d); chk_pins("R10");
                end
                6: begin
                    a = 8'($urandom % 32);
                    bus_read(a, rd); chk("R11 rand read", rd, f_read(a));
                end
                default: begin
                    @(negedge clk);
                    pin_in = 16'($urandom);
                    @(negedge clk);
                    bus_read(8'h10, rd); chk("R9 rand in", rd, {16'h0, pin_in});
                end
            endcase
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule